// File: doc/BRIEF.md
# Asynchronous Serial Receive Engine with Error Status

This block recovers bytes from an asynchronous serial line. It runs from a sample enable (`os_tick`) that pulses 16 times per bit period. The line input passes through a two-stage synchroniser. A falling edge while the receiver is idle starts a frame. The receiver then samples the start bit once at its centre and rejects it as a glitch if the line reads high there. After that it samples each data bit, the optional parity bit and one or two stop bits once at the middle of each bit.

When a frame completes, the shifted byte is either moved into the received-data register or held back, depending on the error status:

- **Overrun:** a frame that ends while the ready flag is still set leaves the data register untouched. It sets the overrun flag together with any framing or parity flag that also applies.
- **Framing or parity error:** the byte is still moved into the data register, but the ready flag is not raised.
- **Line break:** a line held low therefore shows up as a framing error with zero data. Reception continues through the break, so framing errors keep arriving while the line stays low.

Software reads the byte with a read strobe, which drops the ready flag. Each error flag has its own clear strobe. The frame format comes from configuration inputs: 7 or 8 data bits, parity on or off, odd or even parity, and 1 or 2 stop bits. Data arrives least-significant bit first.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_data` is 0x00 and `flag_ready`, `flag_ovr`, `flag_frm` and `flag_par` are all 0.
- R2: Frame reception and ready flag:
  - A frame is a start bit (0), then 8 data bits (7 when `cfg_seven`=1), then a parity bit when `cfg_par_en`=1, then 1 stop bit (2 when `cfg_two_stop`=1). Data bits arrive LSB first.
  - A frame whose stop bit(s) are 1 and whose parity is correct loads `rx_data` and sets `flag_ready`.
  - A 7-bit frame loads bit 7 of `rx_data` as 0.
  - `rd_strobe` clears `flag_ready`.
- R3: Overrun:
  - A frame that completes while `flag_ready`=1 sets `flag_ovr`.
  - `flag_ready` stays at 1 and `rx_data` keeps its earlier value.
- R4: Framing error:
  - A frame with any stop bit sampled as 0 sets `flag_frm`. With two stop bits, either one being 0 counts.
  - The byte is still loaded into `rx_data`, and `flag_ready` is not set.
- R5: Parity error:
  - With `cfg_par_en`=1, the parity bit makes the count of ones over the data and parity bits even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1.
  - A mismatch sets `flag_par`, still loads `rx_data`, and does not set `flag_ready`.
- R6: Combined errors:
  - A framing and parity error in the same frame sets both flags and still loads the byte.
  - Any combination with an overrun sets every flag that applies and leaves `rx_data` unchanged.
- R7: Line break:
  - A line held at 0 gives a framing error with `rx_data`=0x00.
  - If `flag_frm` is cleared while the line stays low, a further framing error follows within one more frame time.
- R8: A low pulse shorter than half a bit period is rejected at the start-bit centre sample. It leaves the data and all flags unchanged.
- R9: Flag retention and clearing:
  - Each error flag stays set until its own clear strobe (`clr_ovr`, `clr_frm`, `clr_par`) is pulsed.
  - A clear strobe affects only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Sample enable, 16 pulses per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 adds a parity bit after the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rd_strobe | input | 1 | Data register read; clears the ready flag |
| clr_ovr | input | 1 | Clears the overrun flag |
| clr_frm | input | 1 | Clears the framing flag |
| clr_par | input | 1 | Clears the parity flag |
| rx_data | output | 8 | Received-data register |
| flag_ready | output | 1 | A good byte is waiting |
| flag_ovr | output | 1 | Overrun flag |
| flag_frm | output | 1 | Framing error flag |
| flag_par | output | 1 | Parity error flag |

## Verification
The assertions assume the following about the inputs:
- `rd_strobe` does not arrive in the same cycle as a frame completion. The bench only reads when the line has been idle for two bit times after a frame.
- Configuration is steady while a frame is in flight. The bench changes the frame format only between frames, with the line idle high.

The stimulus mixes fixed-seed random bytes, formats and error injections with directed cases for overrun, break, glitch and the flag clears.

// File: rtl/serial_rx_pkg.sv
// Package: shared types and constants for the serial receive engine.
// Assumes one sample enable pulse equals one sixteenth of a bit period.
package serial_rx_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int DATA_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous line into the clock domain through a flop chain
// and flags a high-to-low change seen between two sample enables.
// Assumes: STAGES >= 2; the line idles high, so every stage resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_async,
    output logic line_s,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Metastability chain, shifts on every clock
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_async};
    end

    assign line_s = chain_q[STAGES-1];

    // Remembers the line value at the previous sample enable
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= line_s;
    end

    assign fall = tick & prev_q & ~line_s;

endmodule

// File: rtl/rx_framer.sv
// Module: rx_framer
// Frame sequencer. It waits for a start edge, confirms the start bit at
// its centre, then samples data, parity and stop bits at their centres.
// It emits a one-cycle completion pulse carrying the byte and error bits.
// Assumes: configuration is steady during a frame. A frame that ends with
// the line low arms an immediate restart, so a held break keeps framing.
module rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OSR = OVERSAMPLE,
    parameter int DW  = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line_s,
    input  logic          fall,
    input  logic          cfg_seven,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    output logic          done,
    output logic [DW-1:0] frame_data,
    output logic          frame_perr,
    output logic          frame_ferr
);

    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL = CW'(OSR - 1);

    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] shreg_q;
    logic          par_acc_q;
    logic          ferr_acc_q;
    logic          stop_idx_q;
    logic          arm_q;
    logic [BW-1:0] last_bit;
    logic          centre;

    assign last_bit = cfg_seven ? BW'(DW - 2) : BW'(DW - 1);
    assign centre   = tick && (cnt_q == FULL);

    // Frame state machine with sampling counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            par_acc_q  <= 1'b0;
            ferr_acc_q <= 1'b0;
            stop_idx_q <= 1'b0;
            arm_q      <= 1'b0;
            done       <= 1'b0;
            frame_data <= '0;
            frame_perr <= 1'b0;
            frame_ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (line_s) arm_q <= 1'b0;
            if (tick) begin
                case (state_q)
                    ST_IDLE: begin
                        if (!line_s && (fall || arm_q)) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == HALF) begin
                            cnt_q <= '0;
                            if (line_s) begin
                                state_q <= ST_IDLE;
                            end else begin
                                state_q    <= ST_DATA;
                                bit_q      <= '0;
                                shreg_q    <= '0;
                                par_acc_q  <= 1'b0;
                                ferr_acc_q <= 1'b0;
                                stop_idx_q <= 1'b0;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (centre) begin
                            shreg_q   <= {line_s, shreg_q[DW-1:1]};
                            par_acc_q <= par_acc_q ^ line_s;
                            if (bit_q == last_bit)
                                state_q <= cfg_par_en ? ST_PAR : ST_STOP;
                            else
                                bit_q <= bit_q + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (centre) begin
                            par_acc_q <= par_acc_q ^ line_s;
                            state_q   <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (centre) begin
                            ferr_acc_q <= ferr_acc_q | ~line_s;
                            if (cfg_two_stop && !stop_idx_q) begin
                                stop_idx_q <= 1'b1;
                            end else begin
                                state_q    <= ST_IDLE;
                                done       <= 1'b1;
                                frame_ferr <= ferr_acc_q | ~line_s;
                                frame_perr <= cfg_par_en & (par_acc_q ^ cfg_par_odd);
                                frame_data <= cfg_seven ? (shreg_q >> 1) : shreg_q;
                                if (!line_s) arm_q <= 1'b1;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && tick && cnt_q == HALF && line_s) |=> (state_q == ST_IDLE)); // R8

endmodule

// File: rtl/rx_status.sv
// Module: rx_status
// Holds the received-data register and the four status flags. It decides
// from the flag state whether a completed frame's byte is copied.
// Assumes: the read strobe never coincides with a completion pulse; a new
// flag setting wins over a clear strobe in the same cycle.
module rx_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] frame_data,
    input  logic          frame_perr,
    input  logic          frame_ferr,
    input  logic          rd_strobe,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    output logic [DW-1:0] data_q,
    output logic          ready_q,
    output logic          ovr_q,
    output logic          frm_q,
    output logic          par_q
);

    // Flag updates and transfer decision for each completed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
            frm_q   <= 1'b0;
            par_q   <= 1'b0;
        end else begin
            if (rd_strobe) ready_q <= 1'b0;
            if (clr_ovr)   ovr_q   <= 1'b0;
            if (clr_frm)   frm_q   <= 1'b0;
            if (clr_par)   par_q   <= 1'b0;
            if (done) begin
                if (frame_perr) par_q <= 1'b1;
                if (frame_ferr) frm_q <= 1'b1;
                if (ready_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q <= frame_data;
                    if (!frame_perr && !frame_ferr) ready_q <= 1'b1;
                end
            end
        end
    end

    AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ready_q) |=> ($stable(data_q) && ovr_q)); // R3

    AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ready_q && (frame_perr || frame_ferr)) |=> !ready_q); // R4

    AST_GOOD_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ready_q && !frame_perr && !frame_ferr) |=> ready_q); // R2

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_ovr) |=> ovr_q); // R9

    AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q && !clr_frm) |=> frm_q); // R9

endmodule

// File: rtl/serial_rx_core.sv
// Module: serial_rx_core (top)
// Asynchronous serial receiver built from a line synchroniser, a frame
// sequencer and a status/data register stage.
// Assumes: os_tick pulses OVERSAMPLE times per bit; rxd idles high.
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              cfg_seven,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              rd_strobe,
    input  logic              clr_ovr,
    input  logic              clr_frm,
    input  logic              clr_par,
    output logic [DATA_W-1:0] rx_data,
    output logic              flag_ready,
    output logic              flag_ovr,
    output logic              flag_frm,
    output logic              flag_par
);

    logic              line_s;
    logic              fall;
    logic              done;
    logic [DATA_W-1:0] frame_data;
    logic              frame_perr;
    logic              frame_ferr;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line_async (rxd),
        .line_s     (line_s),
        .fall       (fall)
    );

    rx_framer #(.OSR(OVERSAMPLE), .DW(DATA_W)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (os_tick),
        .line_s       (line_s),
        .fall         (fall),
        .cfg_seven    (cfg_seven),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .done         (done),
        .frame_data   (frame_data),
        .frame_perr   (frame_perr),
        .frame_ferr   (frame_ferr)
    );

    rx_status #(.DW(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .frame_data (frame_data),
        .frame_perr (frame_perr),
        .frame_ferr (frame_ferr),
        .rd_strobe  (rd_strobe),
        .clr_ovr    (clr_ovr),
        .clr_frm    (clr_frm),
        .clr_par    (clr_par),
        .data_q     (rx_data),
        .ready_q    (flag_ready),
        .ovr_q      (flag_ovr),
        .frm_q      (flag_frm),
        .par_q      (flag_par)
    );

endmodule

// File: tb/serial_rx_core_tb.sv
// Bench: drives serial frames bit by bit at 16 clocks per bit and checks
// the data register and flags against a behavioural model.
module serial_rx_core_tb_top;

    localparam int BITT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       cfg_seven = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       rd_strobe = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
    logic [7:0] rx_data;
    logic       flag_ready, flag_ovr, flag_frm, flag_par;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [7:0] m_data;
    logic       m_ready, m_ovr, m_frm, m_par;

    always #4 clk = ~clk;

    serial_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .rd_strobe(rd_strobe), .clr_ovr(clr_ovr),
        .clr_frm(clr_frm), .clr_par(clr_par), .rx_data(rx_data),
        .flag_ready(flag_ready), .flag_ovr(flag_ovr), .flag_frm(flag_frm), .flag_par(flag_par)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "rx_data", rx_data, m_data);
        chk(req, "ready", {7'd0, flag_ready}, {7'd0, m_ready});
        chk(req, "ovr", {7'd0, flag_ovr}, {7'd0, m_ovr});
        chk(req, "frm", {7'd0, flag_frm}, {7'd0, m_frm});
        chk(req, "par", {7'd0, flag_par}, {7'd0, m_par});
    endtask

    function automatic logic calc_par(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // bad_stop: 0 none, 1 first stop low, 2 second stop low
    task automatic send_frame(input logic [7:0] d, input logic bad_par, input int bad_stop);
        logic [7:0] dd;
        logic fe, pe;
        int nb;
        nb = cfg_seven ? 7 : 8;
        dd = cfg_seven ? (d & 8'h7F) : d;
        hold(1'b0, BITT);
        for (int i = 0; i < nb; i++) hold(dd[i], BITT);
        if (cfg_par_en) hold(calc_par(dd, cfg_par_odd) ^ bad_par, BITT);
        hold(bad_stop == 1 ? 1'b0 : 1'b1, BITT);
        if (cfg_two_stop) hold(bad_stop == 2 ? 1'b0 : 1'b1, BITT);
        hold(1'b1, 2 * BITT);
        fe = (bad_stop == 1) || (cfg_two_stop && bad_stop == 2);
        pe = cfg_par_en && bad_par;
        if (pe) m_par = 1'b1;
        if (fe) m_frm = 1'b1;
        if (m_ready) m_ovr = 1'b1;
        else begin
            m_data = dd;
            if (!pe && !fe) m_ready = 1'b1;
        end
    endtask

    task automatic pulse(input int which);
        case (which)
            0: begin rd_strobe = 1'b1; m_ready = 1'b0; end
            1: begin clr_ovr = 1'b1; m_ovr = 1'b0; end
            2: begin clr_frm = 1'b1; m_frm = 1'b0; end
            default: begin clr_par = 1'b1; m_par = 1'b0; end
        endcase
        @(negedge clk);
        rd_strobe = 1'b0; clr_ovr = 1'b0; clr_frm = 1'b0; clr_par = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_data = 8'h00; m_ready = 1'b0; m_ovr = 1'b0; m_frm = 1'b0; m_par = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input logic s, input logic pe, input logic po, input logic ts);
        cfg_seven = s; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
        @(negedge clk);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        @(negedge clk);
        do_reset();
        check_all("R1");

        // R2: clean 8N1 frame, then read
        set_cfg(0, 0, 0, 0);
        send_frame(8'hA5, 0, 0);
        check_all("R2");
        pulse(0);
        check_all("R2");

        // R2: 7-bit even parity, two stop bits, top bit of input ignored
        set_cfg(1, 1, 0, 1);
        send_frame(8'hD3, 0, 0);
        check_all("R2");
        pulse(0);

        // R3: overrun keeps first byte
        set_cfg(0, 0, 0, 0);
        send_frame(8'h3C, 0, 0);
        send_frame(8'hC3, 0, 0);
        check_all("R3");
        pulse(0); pulse(1);
        check_all("R9");

        // R4: framing error on first stop; then on second stop of two
        send_frame(8'h81, 0, 1);
        check_all("R4");
        pulse(2);
        set_cfg(0, 0, 0, 1);
        send_frame(8'h42, 0, 2);
        check_all("R4");
        pulse(2);

        // R5: odd parity mismatch
        set_cfg(0, 1, 1, 0);
        send_frame(8'h5A, 1, 0);
        check_all("R5");
        pulse(3);
        send_frame(8'h5B, 0, 0);
        check_all("R5");
        pulse(0);

        // R6: framing plus parity together, then overrun plus parity
        send_frame(8'h77, 1, 1);
        check_all("R6");
        pulse(2); pulse(3);
        check_all("R9");
        send_frame(8'h11, 0, 0);
        send_frame(8'h22, 1, 0);
        check_all("R6");
        // R9: clearing parity leaves overrun set
        pulse(3);
        check_all("R9");
        pulse(0); pulse(1);

        // R8: short glitch rejected
        set_cfg(0, 0, 0, 0);
        hold(1'b0, 4);
        hold(1'b1, 3 * BITT);
        check_all("R8");

        // R7: break gives framing error with zero data, repeats after clear
        hold(1'b0, 11 * BITT);
        m_frm = 1'b1; m_data = 8'h00;
        check_all("R7");
        pulse(2);
        rxd = 1'b0;
        repeat (11 * BITT) @(negedge clk);
        m_frm = 1'b1;
        check_all("R7");
        hold(1'b1, 14 * BITT);
        do_reset();
        check_all("R1");

        // Random frames against the model
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            logic bp;
            int bs;
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            d  = 8'($urandom);
            bp = ($urandom % 8) == 0;
            bs = ($urandom % 8) == 0 ? (cfg_two_stop ? 1 + int'($urandom % 2) : 1) : 0;
            send_frame(d, bp, bs);
            check_all("R2 R3 R4 R5 R6");
            if (($urandom % 4) != 0) pulse(0);
            if (($urandom % 3) == 0) begin pulse(1); pulse(2); pulse(3); check_all("R9"); end
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule